// File: doc/BRIEF.md
# Hysteretic Charger Detect Controller

This block decides whether an upstream charger is present by comparing signed pack-side and battery-side voltage samples, both in millivolts. Setting the detect flag and clearing it use two different tests. The flag sets when the pack is above the battery by at least the entry threshold. It clears when the battery is above the pack by at least the exit threshold. Between the two tests the flag holds its value. This dead band stops measurement noise from toggling the flag when the two voltages are close together.

Two mode bits are derived from the detect flag and a linear-charger enable. Linear mode means the charger is detected and linear charging is enabled. Ideal-diode mode means no charger is detected. The detect flag, the two mode bits and the enable together form a 4-bit status word that feeds the downstream charge and switch state machines.

A parallel-pack configuration input turns off the voltage-based update. In that mode a host sets the flag by sending a fixed-length byte frame. The frame carries a command code, a data byte and a checksum. Only bit 1 of the data byte is used, and the mode bits go on being derived from whatever flag results.

Top module: `chgdet_ctrl`

## Requirements
- R1: After reset the detect flag is 0, the entry threshold is 0 mV, the exit threshold is 10 mV, and `host_err` is 0.
- R2: On a clock edge with `smp_vld` high and `par_mode` low, the detect flag becomes 1 from the next cycle on if (pack − battery) is at least the entry threshold and the exit test does not hold.
- R3: On a clock edge with `smp_vld` high and `par_mode` low, the detect flag becomes 0 from the next cycle on if (battery − pack) is at least the exit threshold. When both tests hold at once, the exit test wins.
- R4: The detect flag keeps its value on any edge where no valid sample, threshold test or accepted host frame changes it.
- R5: Both differences are formed at 17 bits, so full-scale inputs of opposite signs (for example 32767 against −32768) compare correctly.
- R6: A threshold write is taken at the edge where `thr_we` is high. `thr_sel` 0 selects the entry threshold and 1 selects the exit threshold. The value is signed 16-bit, and samples on later edges use it.
- R7: `status` bit 0 equals `lin_en`. Bit 1 is the detect flag. Bit 2 is (flag AND `lin_en`). Bit 3 is NOT flag. Bits 0 and 2 follow `lin_en` in the same cycle.
- R8: While `par_mode` is 1, voltage samples have no effect on the detect flag.
- R9: A host frame is 36 bytes, each presented with `hb_vld`. `hb_first` marks byte 0, and a new `hb_first` restarts the frame. Bytes 0 and 1 must be 0xB5 and 0x00. Byte 2 is data. Byte 34 must equal the bitwise inverse of the low 8 bits of the sum of bytes 0 to 33. Byte 35 is a length byte and is not checked. When `par_mode` is 1, a valid frame loads data bit 1 into the flag one cycle after the edge of byte 35.
- R10: A frame with the correct command code is rejected if its checksum is wrong or if `par_mode` is 0. A rejected frame leaves the flag unchanged and drives `host_err` high for exactly the cycle after byte 35. A frame with a wrong command code is dropped with no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| par_mode | input | 1 | 1: host-controlled detect flag; 0: voltage-based detect |
| lin_en | input | 1 | Linear charger enabled |
| smp_vld | input | 1 | Voltage sample strobe |
| vpack_mv | input | 16 | Pack voltage, signed mV |
| vbat_mv | input | 16 | Battery voltage, signed mV |
| thr_we | input | 1 | Threshold write strobe |
| thr_sel | input | 1 | 0 entry threshold, 1 exit threshold |
| thr_wdata | input | 16 | Signed threshold value, mV |
| hb_vld | input | 1 | Host frame byte valid |
| hb_first | input | 1 | Byte is byte 0 of a frame |
| hb_byte | input | 8 | Host frame byte |
| status | output | 4 | {ideal-diode, linear, detect, lin_en} |
| host_err | output | 1 | One-cycle pulse for a rejected host frame |

## Verification
A sample, a threshold write or the last byte of a frame takes effect at the clock edge that accepts it. The flag, the linear bit and the ideal-diode bit then change one cycle later, and `host_err` pulses in that same following cycle. Status bits 0 and 2 are different: they follow `lin_en` with no register in the path. The bench changes inputs just after each rising edge and updates its behavioural model at that same edge. It compares `status` and `host_err` with the model at every falling edge, so each register delay is counted exactly once and combinational paths are seen in the cycle they act.

// File: rtl/chgdet_pkg.sv
package chgdet_pkg;

    typedef enum logic {
        THR_ENTRY = 1'b0,
        THR_EXIT  = 1'b1
    } thr_sel_e;

    localparam int ST_LINEN = 0;
    localparam int ST_DET   = 1;
    localparam int ST_LIN   = 2;
    localparam int ST_IDEAL = 3;
    localparam int ST_W     = 4;

endpackage

// File: rtl/chgdet_hyst.sv
module chgdet_hyst
    import chgdet_pkg::*;
#(
    parameter int             VW      = 16,
    parameter logic [VW-1:0]  ON_RST  = '0,
    parameter logic [VW-1:0]  OFF_RST = VW'(10)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          par_mode,
    input  logic          smp_vld,
    input  logic [VW-1:0] vpack,
    input  logic [VW-1:0] vbat,
    input  logic          thr_we,
    input  thr_sel_e      thr_sel,
    input  logic [VW-1:0] thr_wdata,
    input  logic          host_wr,
    input  logic          host_det,
    output logic          det
);
    localparam int DW = VW + 1;

    typedef struct packed {
        logic          det;
        logic [VW-1:0] on_thr;
        logic [VW-1:0] off_thr;
    } st_t;

    st_t st_d, st_q;
    logic signed [DW-1:0] diff_up, diff_dn;
    logic enter, leave;

    always_comb begin
        diff_up = $signed({vpack[VW-1], vpack}) - $signed({vbat[VW-1], vbat});
        diff_dn = $signed({vbat[VW-1], vbat}) - $signed({vpack[VW-1], vpack});
        enter   = diff_up >= $signed({st_q.on_thr[VW-1], st_q.on_thr});
        leave   = diff_dn >= $signed({st_q.off_thr[VW-1], st_q.off_thr});

        st_d = st_q;
        if (thr_we) begin
            if (thr_sel == THR_ENTRY) st_d.on_thr  = thr_wdata;
            else                      st_d.off_thr = thr_wdata;
        end
        if (par_mode) begin
            if (host_wr) st_d.det = host_det;
        end else if (smp_vld) begin
            if (leave)      st_d.det = 1'b0;
            else if (enter) st_d.det = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.det     <= 1'b0;
            st_q.on_thr  <= ON_RST;
            st_q.off_thr <= OFF_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign det = st_q.det;

    AST_ENTRY_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_vld && !par_mode && enter && !leave) |=> det); // R2
    AST_EXIT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_vld && !par_mode && leave) |=> !det); // R3
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!smp_vld && !host_wr) |=> $stable(det)); // R4
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        ($signed(vpack) >= $signed(vbat)) |-> (!diff_up[DW-1] && (diff_dn <= 0))); // R5
    AST_PAR_IGNORES_SMP: assert property (@(posedge clk) disable iff (!rst_n)
        (par_mode && !host_wr) |=> $stable(det)); // R8
endmodule

// File: rtl/chgdet_frame_rx.sv
module chgdet_frame_rx #(
    parameter int          FRAME_LEN = 36,
    parameter int          DATA_POS  = 2,
    parameter int          CKS_POS   = 34,
    parameter logic [7:0]  CMD_LO    = 8'hB5,
    parameter logic [7:0]  CMD_HI    = 8'h00,
    parameter int          DET_BIT   = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       par_mode,
    input  logic       hb_vld,
    input  logic       hb_first,
    input  logic [7:0] hb_byte,
    output logic       host_wr,
    output logic       host_det,
    output logic       host_err
);
    localparam int IW = $clog2(FRAME_LEN + 1);
    localparam logic [IW-1:0] LAST_IDX = IW'(FRAME_LEN - 1);
    localparam logic [IW-1:0] CKS_IDX  = IW'(CKS_POS);
    localparam logic [IW-1:0] DATA_IDX = IW'(DATA_POS);

    typedef struct packed {
        logic          busy;
        logic [IW-1:0] idx;
        logic [7:0]    sum;
        logic [7:0]    data;
        logic [7:0]    cks;
        logic          cmd_ok;
        logic          err;
    } st_t;

    st_t  st_d, st_q;
    logic done, cks_ok;

    always_comb begin
        st_d     = st_q;
        st_d.err = 1'b0;
        done     = 1'b0;
        cks_ok   = (st_q.cks == ~st_q.sum);
        if (hb_vld) begin
            if (hb_first) begin
                st_d.busy   = 1'b1;
                st_d.idx    = IW'(1);
                st_d.sum    = hb_byte;
                st_d.cmd_ok = (hb_byte == CMD_LO);
            end else if (st_q.busy) begin
                if (st_q.idx < CKS_IDX)  st_d.sum    = st_q.sum + hb_byte;
                if (st_q.idx == IW'(1))  st_d.cmd_ok = st_q.cmd_ok && (hb_byte == CMD_HI);
                if (st_q.idx == DATA_IDX) st_d.data  = hb_byte;
                if (st_q.idx == CKS_IDX)  st_d.cks   = hb_byte;
                if (st_q.idx == LAST_IDX) begin
                    done      = 1'b1;
                    st_d.busy = 1'b0;
                end
                st_d.idx = st_q.idx + IW'(1);
            end
        end
        host_wr  = done && st_q.cmd_ok && cks_ok && par_mode;
        st_d.err = done && st_q.cmd_ok && (!cks_ok || !par_mode);
        host_det = st_q.data[DET_BIT];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign host_err = st_q.err;

    AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        host_err |=> !host_err); // R10
    AST_WR_NEEDS_PAR: assert property (@(posedge clk) disable iff (!rst_n)
        host_wr |-> (par_mode && !st_d.err)); // R9
endmodule

// File: rtl/chgdet_ctrl.sv
module chgdet_ctrl
    import chgdet_pkg::*;
#(
    parameter int VW        = 16,
    parameter int FRAME_LEN = 36
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          par_mode,
    input  logic          lin_en,
    input  logic          smp_vld,
    input  logic [VW-1:0] vpack_mv,
    input  logic [VW-1:0] vbat_mv,
    input  logic          thr_we,
    input  logic          thr_sel,
    input  logic [VW-1:0] thr_wdata,
    input  logic          hb_vld,
    input  logic          hb_first,
    input  logic [7:0]    hb_byte,
    output logic [3:0]    status,
    output logic          host_err
);
    logic host_wr, host_det, det;

    chgdet_frame_rx #(
        .FRAME_LEN (FRAME_LEN),
        .DATA_POS  (2),
        .CKS_POS   (FRAME_LEN - 2),
        .DET_BIT   (ST_DET)
    ) i_frame_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .par_mode (par_mode),
        .hb_vld   (hb_vld),
        .hb_first (hb_first),
        .hb_byte  (hb_byte),
        .host_wr  (host_wr),
        .host_det (host_det),
        .host_err (host_err)
    );

    chgdet_hyst #(
        .VW (VW)
    ) i_hyst (
        .clk       (clk),
        .rst_n     (rst_n),
        .par_mode  (par_mode),
        .smp_vld   (smp_vld),
        .vpack     (vpack_mv),
        .vbat      (vbat_mv),
        .thr_we    (thr_we),
        .thr_sel   (thr_sel_e'(thr_sel)),
        .thr_wdata (thr_wdata),
        .host_wr   (host_wr),
        .host_det  (host_det),
        .det       (det)
    );

    always_comb begin
        status           = '0;
        status[ST_LINEN] = lin_en;
        status[ST_DET]   = det;
        status[ST_LIN]   = det && lin_en;
        status[ST_IDEAL] = !det;
    end

    AST_LIN_NEEDS_DET: assert property (@(posedge clk) disable iff (!rst_n)
        status[ST_LIN] |-> (status[ST_DET] && status[ST_LINEN])); // R7
    AST_MODES_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(status[ST_LIN] && status[ST_IDEAL])); // R7
endmodule

// File: tb/test_chgdet_ctrl.sv
module test_chgdet_ctrl;
    localparam int CLK_P = 10;
    localparam int FLEN  = 36;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic par_mode = 0, lin_en = 0, smp_vld = 0, thr_we = 0, thr_sel = 0;
    logic hb_vld = 0, hb_first = 0;
    logic [7:0]  hb_byte = '0;
    logic [15:0] vpack_mv = '0, vbat_mv = '0, thr_wdata = '0;
    logic [3:0]  status;
    logic        host_err;

    int n_chk = 0, n_fail = 0;
    string cur_req = "R1";

    chgdet_ctrl i_chgdet_ctrl (
        .clk(clk), .rst_n(rst_n), .par_mode(par_mode), .lin_en(lin_en),
        .smp_vld(smp_vld), .vpack_mv(vpack_mv), .vbat_mv(vbat_mv),
        .thr_we(thr_we), .thr_sel(thr_sel), .thr_wdata(thr_wdata),
        .hb_vld(hb_vld), .hb_first(hb_first), .hb_byte(hb_byte),
        .status(status), .host_err(host_err)
    );

    always #(CLK_P/2) clk = ~clk;

    // behavioural reference
    bit m_det = 0, m_err = 0;
    int m_on = 0, m_off = 10;
    bit [7:0] fq[$];

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_det = 0; m_err = 0; m_on = 0; m_off = 10; fq = {};
        end else begin
            bit nxt_det;
            bit nxt_err;
            int up, dn;
            nxt_det = m_det;
            nxt_err = 0;
            up = int'($signed(vpack_mv)) - int'($signed(vbat_mv));
            dn = -up;
            if (!par_mode && smp_vld) begin
                if (dn >= m_off)     nxt_det = 0;
                else if (up >= m_on) nxt_det = 1;
            end
            if (hb_vld) begin
                if (hb_first) begin fq = {}; fq.push_back(hb_byte); end
                else if (fq.size() > 0) fq.push_back(hb_byte);
            end
            if (fq.size() == FLEN) begin
                int s;
                bit ck, cmd;
                s = 0;
                for (int i = 0; i < FLEN - 2; i++) s += fq[i];
                ck  = (fq[FLEN-2] == ~(s[7:0]));
                cmd = (fq[0] == 8'hB5) && (fq[1] == 8'h00);
                nxt_err = cmd && (!ck || !par_mode);
                if (cmd && ck && par_mode) nxt_det = fq[2][1];
                fq = {};
            end
            if (thr_we) begin
                if (thr_sel) m_off = int'($signed(thr_wdata));
                else         m_on  = int'($signed(thr_wdata));
            end
            m_det = nxt_det;
            m_err = nxt_err;
        end
    end

    always @(negedge clk) begin
        logic [3:0] exp_st;
        exp_st = {~m_det, m_det & lin_en, m_det, lin_en};
        n_chk++;
        if (status !== exp_st) begin
            n_fail++;
            $display("FAIL %s status actual=%b expected=%b at %0t", cur_req, status, exp_st, $time);
        end
        n_chk++;
        if (host_err !== m_err) begin
            n_fail++;
            $display("FAIL %s host_err actual=%b expected=%b at %0t", cur_req, host_err, m_err, $time);
        end
    end

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic sample(input int p, input int b);
        step(); vpack_mv = 16'(p); vbat_mv = 16'(b); smp_vld = 1;
        step(); smp_vld = 0;
    endtask

    task automatic wthr(input bit sel, input int v);
        step(); thr_we = 1; thr_sel = sel; thr_wdata = 16'(v);
        step(); thr_we = 0;
    endtask

    task automatic frame(input bit [7:0] c0, input bit [7:0] d, input bit [7:0] ck, input int nb);
        for (int i = 0; i < nb; i++) begin
            step(); hb_vld = 1; hb_first = (i == 0);
            hb_byte = (i == 0) ? c0 : (i == 2) ? d : (i == FLEN-2) ? ck : (i == FLEN-1) ? 8'h06 : 8'h00;
        end
        step(); hb_vld = 0; hb_first = 0;
        step();
    endtask

    initial begin
        #(CLK_P * 200000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        cur_req = "R1";
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        step(); step();
        lin_en = 1;
        // R2: equal voltages meet the 0 mV entry threshold
        cur_req = "R2"; sample(3700, 3700); step();
        // R4: inside the band, and unstrobed inputs
        cur_req = "R4"; sample(3695, 3700);
        vpack_mv = 16'(1000); step(); step();
        // R3: exit at exactly 10 mV below
        cur_req = "R3"; sample(3690, 3700); step();
        // R6: signed thresholds
        cur_req = "R6"; wthr(0, 150); wthr(1, -5);
        sample(3800, 3700); sample(3850, 3700); sample(3703, 3700); sample(3850, 3700);
        // R3: both tests true, exit wins
        cur_req = "R3"; wthr(0, -20); wthr(1, -20); sample(3700, 3700);
        // R5: full-scale extremes
        cur_req = "R5"; wthr(0, 32767); wthr(1, 32767);
        sample(32767, -32768); sample(-32768, 32767); sample(32767, -32768);
        // R7: lin_en toggles with flag set and clear
        cur_req = "R7"; lin_en = 0; step(); lin_en = 1; step();
        sample(-32768, 32767); lin_en = 0; step(); lin_en = 1; step();
        wthr(0, 0); wthr(1, 10);
        // R8: parallel mode ignores samples
        cur_req = "R8"; par_mode = 1; sample(3800, 3700); sample(3600, 3700);
        // R9: valid host frames
        cur_req = "R9"; frame(8'hB5, 8'h02, 8'h48, FLEN);
        frame(8'hB5, 8'h00, 8'h4A, FLEN);
        frame(8'hB5, 8'h02, 8'h00, 10);
        frame(8'hB5, 8'h02, 8'h48, FLEN);
        // R10: rejected frames
        cur_req = "R10"; frame(8'hB5, 8'h00, 8'h4B, FLEN);
        frame(8'hB4, 8'h00, 8'h4B, FLEN);
        par_mode = 0; sample(3600, 3700);
        frame(8'hB5, 8'h02, 8'h48, FLEN);
        // R4: random mix near the band
        cur_req = "R4";
        for (int k = 0; k < 400; k++) begin
            step();
            smp_vld  = 1'($urandom_range(0, 1));
            lin_en   = 1'($urandom_range(0, 1));
            vbat_mv  = 16'(3700);
            vpack_mv = 16'(3700 + int'($urandom_range(0, 40)) - 20);
        end
        step(); smp_vld = 0; step(); step();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule